// File: doc/BRIEF.md
# Level-Sensitive Second-Level Interrupt Aggregator

This block gathers a set of level-sensitive interrupt sources behind one enable register and drives a small number of upstream interrupt lines. Each upstream line has its own fixed routing mask. A line asserts when at least one source inside its mask is both active and enabled. Status is a live view of enabled, active sources. Nothing is latched, so there is nothing to acknowledge or clear: a source stays visible until it drops its level.

A fixed forward mask chooses which sources are enabled out of reset. It is also folded into the enable state whenever that state is saved. A save pulse stores the current enables together with the forward mask. If the instance is built with wake support, the save pulse also widens the live enables by the wake-armed set, so those sources can still raise a line while the system is in low power. A restore pulse loads the stored value back into the enable register.

Software uses a plain register bus with address, write strobe, write data and read data. Read data is registered and appears one clock after the address is presented.

Top module: `l2_irq_aggregator`

## Requirements
- R1: While reset is held, and after it is released, the enable register holds the forward mask `FWD_MASK`, all parent outputs are 0 and read data is 0.
- R2: A write with `bus_addr` = 0x0 loads `bus_wdata` into the enable register. Bit n enables source n.
- R3: A read of `bus_addr` = 0x4 returns `src_level & enable` as it stood at the clock edge that captures the address. A write to 0x4 leaves the enable register unchanged.
- R4: A read at any address other than 0x0 and 0x4 returns zero. A write to any such address leaves the enable register unchanged.
- R5: Parent output p is registered. After each clock edge it equals the OR-reduction of `src_level & enable & MAP_MASK[p]` sampled at that edge.
- R6: A source that is outside every parent's routing mask never asserts any parent output, even when it is enabled and active.
- R7: A `save_req` pulse stores `enable | FWD_MASK`. When `WAKE_EN` = 1, the same pulse loads the enable register with `enable | FWD_MASK | wake_active`. When `WAKE_EN` = 0, the enable register is left unchanged.
- R8: A `restore_req` pulse loads the enable register with the last stored value. Before the first save, the stored value is `FWD_MASK`.
- R9: When requests fall in the same cycle, the priority is `save_req`, then `restore_req`, then a bus write. Only the highest-priority request takes effect.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | NSRC | Level of each interrupt source |
| wake_active | input | NSRC | Wake-armed sources, used by save |
| save_req | input | 1 | Save enable state (one-cycle pulse) |
| restore_req | input | 1 | Restore enable state (one-cycle pulse) |
| bus_addr | input | AW | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Registered read data |
| parent_irq | output | NPARENT | Upstream interrupt lines |

## Verification
The checker tests four things on every clock edge:
- each parent line against the sources, enables and mask sampled one edge earlier;
- the status read and the zero read for unmapped addresses;
- the result of each save and restore, including the priority order.

Some behaviour can only be shown by the bench's scenarios:
- the reset value;
- writes to status or unmapped offsets having no effect;
- an enabled source outside every mask staying silent;
- a restore that follows a wake-widened save.

For these, the bench compares its own model against the outputs on every cycle.

// File: rtl/l2_irq_pkg.sv
package l2_irq_pkg;
  localparam int unsigned OFS_ENABLE = 0;
  localparam int unsigned OFS_STATUS = 4;
endpackage

// File: rtl/l2_en_ctrl.sv
module l2_en_ctrl #(
  parameter int unsigned NSRC     = 32,
  parameter int unsigned AW       = 4,
  parameter logic [NSRC-1:0] FWD_MASK = '0,
  parameter bit WAKE_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic [NSRC-1:0] wake_active,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] saved_q
);
  import l2_irq_pkg::*;

  logic            wr_en_hit;
  logic [NSRC-1:0] save_val;

  assign wr_en_hit = bus_we && (bus_addr == AW'(OFS_ENABLE));
  assign save_val  = en_q | FWD_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= FWD_MASK;
      saved_q <= FWD_MASK;
    end else if (save_req) begin
      saved_q <= save_val;
      if (WAKE_EN) en_q <= save_val | wake_active;
    end else if (restore_req) begin
      en_q <= saved_q;
    end else if (wr_en_hit) begin
      en_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/l2_route.sv
module l2_route #(
  parameter int unsigned NSRC    = 32,
  parameter int unsigned NPARENT = 2,
  parameter logic [NPARENT*NSRC-1:0] MAP_MASK = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    pend,
  output logic [NPARENT-1:0] parent_irq
);
  for (genvar p = 0; p < NPARENT; p++) begin : g_parent
    localparam logic [NSRC-1:0] PMASK = MAP_MASK[p*NSRC +: NSRC];
    always_ff @(posedge clk) begin
      if (rst) parent_irq[p] <= 1'b0;
      else     parent_irq[p] <= |(pend & PMASK);
    end
  end
endmodule

// File: rtl/l2_regread.sv
module l2_regread #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] bus_rdata
);
  import l2_irq_pkg::*;

  logic [NSRC-1:0] rd_mux;

  always_comb begin
    unique case (bus_addr)
      AW'(OFS_ENABLE): rd_mux = en_q;
      AW'(OFS_STATUS): rd_mux = pend;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/l2_irq_aggregator.sv
module l2_irq_aggregator #(
  parameter int unsigned NSRC    = 32,
  parameter int unsigned NPARENT = 2,
  parameter int unsigned AW      = 4,
  parameter logic [NSRC-1:0] FWD_MASK = 32'h0000_0003,
  parameter logic [NPARENT*NSRC-1:0] MAP_MASK = {32'h00FF_0F00, 32'h0000_FFFF},
  parameter bit WAKE_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    src_level,
  input  logic [NSRC-1:0]    wake_active,
  input  logic               save_req,
  input  logic               restore_req,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_we,
  input  logic [NSRC-1:0]    bus_wdata,
  output logic [NSRC-1:0]    bus_rdata,
  output logic [NPARENT-1:0] parent_irq
);
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] saved_q;
  logic [NSRC-1:0] pend;

  assign pend = src_level & en_q;

  l2_en_ctrl #(.NSRC(NSRC), .AW(AW), .FWD_MASK(FWD_MASK), .WAKE_EN(WAKE_EN)) u_en (
    .clk(clk), .rst(rst), .save_req(save_req), .restore_req(restore_req),
    .wake_active(wake_active), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .en_q(en_q), .saved_q(saved_q)
  );

  l2_route #(.NSRC(NSRC), .NPARENT(NPARENT), .MAP_MASK(MAP_MASK)) u_route (
    .clk(clk), .rst(rst), .pend(pend), .parent_irq(parent_irq)
  );

  l2_regread #(.NSRC(NSRC), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .en_q(en_q), .pend(pend),
    .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/l2_irq_aggregator_chk.sv
module l2_irq_aggregator_chk #(
  parameter int unsigned NSRC    = 32,
  parameter int unsigned NPARENT = 2,
  parameter int unsigned AW      = 4,
  parameter logic [NSRC-1:0] FWD_MASK = '0,
  parameter logic [NPARENT*NSRC-1:0] MAP_MASK = '1,
  parameter bit WAKE_EN = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic [NSRC-1:0]    src_level,
  input logic [NSRC-1:0]    wake_active,
  input logic               save_req,
  input logic               restore_req,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_we,
  input logic [NSRC-1:0]    bus_wdata,
  input logic [NSRC-1:0]    bus_rdata,
  input logic [NPARENT-1:0] parent_irq,
  input logic [NSRC-1:0]    en_q,
  input logic [NSRC-1:0]    saved_q
);
  for (genvar p = 0; p < NPARENT; p++) begin : g_chk
    localparam logic [NSRC-1:0] PM = MAP_MASK[p*NSRC +: NSRC];
    // R5 / R6
    a_r5_parent_level: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> parent_irq[p] == $past(|(src_level & en_q & PM)));
  end

  a_r3_status_read: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) == AW'(4)) |-> bus_rdata == $past(src_level & en_q));

  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) != AW'(0) && $past(bus_addr) != AW'(4)) |-> bus_rdata == '0);

  a_r7_save_store: assert property (@(posedge clk) disable iff (rst)
    save_req |=> saved_q == ($past(en_q) | FWD_MASK));

  a_r7_save_enable: assert property (@(posedge clk) disable iff (rst)
    save_req |=> en_q == (WAKE_EN ? ($past(en_q) | FWD_MASK | $past(wake_active)) : $past(en_q)));

  a_r9_restore: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !save_req) |=> en_q == $past(saved_q));
endmodule

bind l2_irq_aggregator l2_irq_aggregator_chk #(
  .NSRC(NSRC), .NPARENT(NPARENT), .AW(AW), .FWD_MASK(FWD_MASK),
  .MAP_MASK(MAP_MASK), .WAKE_EN(WAKE_EN)
) u_chk (
  .clk(clk), .rst(rst), .src_level(src_level), .wake_active(wake_active),
  .save_req(save_req), .restore_req(restore_req), .bus_addr(bus_addr),
  .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .parent_irq(parent_irq), .en_q(en_q), .saved_q(saved_q)
);

// File: tb/l2_irq_aggregator_test.sv
module l2_irq_aggregator_test;
  localparam int NSRC = 32;
  localparam int NP   = 2;
  localparam logic [NSRC-1:0] FWD  = 32'h0000_0003;
  localparam logic [NSRC-1:0] MAP0 = 32'h0000_FFFF;
  localparam logic [NSRC-1:0] MAP1 = 32'h00FF_0F00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] src_level = '0, wake_active = '0, bus_wdata = '0;
  logic save_req = 1'b0, restore_req = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [NSRC-1:0] bus_rdata;
  logic [NP-1:0] parent_irq;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";
  bit started = 1'b0;

  logic [NSRC-1:0] m_en, m_saved, m_rd;
  logic [NP-1:0]   m_par;

  always #5 clk = ~clk;

  l2_irq_aggregator uut (
    .clk(clk), .rst(rst), .src_level(src_level), .wake_active(wake_active),
    .save_req(save_req), .restore_req(restore_req), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .parent_irq(parent_irq)
  );

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      m_en = FWD; m_saved = FWD; m_rd = '0; m_par = '0;
    end else begin
      m_par[0] = (src_level & m_en & MAP0) != 0;
      m_par[1] = (src_level & m_en & MAP1) != 0;
      if (bus_addr == 4'h0)      m_rd = m_en;
      else if (bus_addr == 4'h4) m_rd = src_level & m_en;
      else                       m_rd = '0;
      if (save_req) begin
        m_saved = m_en | FWD;
        m_en    = m_saved | wake_active;
      end else if (restore_req) m_en = m_saved;
      else if (bus_we && bus_addr == 4'h0) m_en = bus_wdata;
    end
  end

  task automatic check_now();
    checks++;
    if (bus_rdata !== m_rd || parent_irq !== m_par) begin
      errors++;
      $display("FAIL %s: rdata=%h parent=%b expected rdata=%h parent=%b",
               tag, bus_rdata, parent_irq, m_rd, m_par);
    end
  endtask

  always @(negedge clk) if (started) check_now();

  task automatic step(input logic [3:0] a, input logic we, input logic [NSRC-1:0] wd,
                      input logic sv = 1'b0, input logic rs = 1'b0);
    bus_addr = a; bus_we = we; bus_wdata = wd; save_req = sv; restore_req = rs;
    @(negedge clk);
    bus_we = 1'b0; save_req = 1'b0; restore_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; rst = 1'b0;
    step(4'h0, 1'b0, '0);
    step(4'h0, 1'b0, '0);
    tag = "R5"; src_level = 32'h0000_0001; step(4'h4, 1'b0, '0); step(4'h4, 1'b0, '0);
    tag = "R2"; step(4'h0, 1'b1, 32'hFFFF_FFF0); step(4'h0, 1'b0, '0);
    tag = "R5"; src_level = 32'h0000_0100; step(4'h4, 1'b0, '0); step(4'h4, 1'b0, '0);
    src_level = 32'h0001_0000; step(4'h4, 1'b0, '0); step(4'h4, 1'b0, '0);
    tag = "R6"; src_level = 32'hFF00_0000; step(4'h4, 1'b0, '0); step(4'h0, 1'b0, '0);
    tag = "R3"; src_level = 32'h0F0F_0F0F; step(4'h4, 1'b1, 32'h0000_0000); step(4'h0, 1'b0, '0);
    step(4'h4, 1'b0, '0);
    tag = "R4"; step(4'h8, 1'b1, 32'h1234_5678); step(4'hC, 1'b0, '0); step(4'h0, 1'b0, '0);
    tag = "R2"; step(4'h0, 1'b1, 32'h0000_0010); step(4'h0, 1'b0, '0);
    tag = "R7"; wake_active = 32'h0000_0200; step(4'h0, 1'b0, '0, 1'b1); step(4'h0, 1'b0, '0);
    src_level = 32'h0000_0200; step(4'h4, 1'b0, '0); step(4'h4, 1'b0, '0);
    tag = "R8"; step(4'h0, 1'b1, 32'h0); step(4'h0, 1'b0, '0, 1'b0, 1'b1); step(4'h0, 1'b0, '0);
    tag = "R9"; step(4'h0, 1'b1, 32'hAAAA_0000, 1'b0, 1'b1); step(4'h0, 1'b0, '0);
    step(4'h0, 1'b1, 32'h5555_0000, 1'b1, 1'b1); step(4'h0, 1'b0, '0);
    for (int i = 0; i < 40; i++) begin
      tag = "R5";
      src_level = {$urandom}; wake_active = {$urandom};
      step(4'(((i % 4) * 4)), (i % 3) == 0, {$urandom}, (i % 11) == 5, (i % 7) == 3);
    end
    step(4'h0, 1'b0, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule